// File: doc/BRIEF.md
# Prescaled Match Timer with Single-Edge PWM and Capture-Edge Clear

The block is a free-running up-counter paced by a programmable prescaler. Three output channels each compare the count against their own match value. A fourth match register sets the period: when the count has reached it, the next advance returns the count to zero. Each channel either produces a single-edge PWM waveform or drives a level held in a software-written bit. In PWM mode the output goes high when the count steps onto the channel's match value, and it goes low when the count returns to zero.

A selected edge on one of four asynchronous capture inputs can restart the counter and the prescaler together. This lets an external event set the PWM phase. Software programs the block through a single-cycle register write port with a combinational read path.

Register map (word addresses on `addr_i`, values right-aligned):

| Addr | Content |
|------|---------|
| 0x0 | prescale limit, PRE_W bits |
| 0x1 | current count, read only; writes ignored |
| 0x2 | period value, CNT_W bits |
| 0x3 | clear config: bit 4 enable, bits 7:5 edge select |
| 0x4 | mode: bit i = 1 puts channel i in PWM mode |
| 0x5 | level bits: bit i drives channel i in match mode |
| 0x8+i | match value of channel i |

Top module: `pwm_match_timer`

## Requirements
- R1: After reset every register reads 0 and all three outputs are low.
- R2: With prescale limit L, the count advances by one once every L+1 clocks.
- R3: When the count holds the period value, its next advance produces 0 instead of period+1.
- R4: A channel in PWM mode drives its output high on the advance that brings the count to that channel's match value.
- R5: A channel in PWM mode drives its output low when the count returns to zero, whether through the period rollover or through a capture clear.
- R6: A match that falls on the same advance as the rollover loses: with a match value of 0, a PWM output never goes high.
- R7: A channel whose mode bit (address 0x4, bit i) is 0 drives its output from level bit i at address 0x5, one clock after the write.
- R8: With clear-config bit 4 set, bits 7:5 select the edge. Bit 5 = 1 selects falling and 0 selects rising, and bits 7:6 give the capture channel. The selected edge clears the count and the prescaler on the third clock edge after the input changes.
- R9: A capture edge that is not selected, or any edge while bit 4 is 0, leaves the count unchanged.
- R10: Register bits outside the defined fields read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 4 | register word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i, combinational |
| cap_i | input | 4 | asynchronous capture inputs |
| pwm_o | output | 3 | channel outputs |

## Verification
Two events compete in the same clock. The first pair is a channel match and the period rollover. Channel 2 is given a match value of 0, so its match always falls on the rollover advance, and the scoreboard expects that output to stay low for the whole run. The second pair is a capture clear and an ordinary count advance. The clear is started at an arbitrary prescaler phase, and every later output and count value is predicted from the clear instant alone, so any leftover prescaler phase shows up as a shifted waveform.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_PRESCALE   = 4'h0;
  localparam logic [ADDR_W-1:0] A_COUNT      = 4'h1;
  localparam logic [ADDR_W-1:0] A_PERIOD     = 4'h2;
  localparam logic [ADDR_W-1:0] A_CLRCFG     = 4'h3;
  localparam logic [ADDR_W-1:0] A_MODE       = 4'h4;
  localparam logic [ADDR_W-1:0] A_LEVEL      = 4'h5;
  localparam logic [ADDR_W-1:0] A_MATCH_BASE = 4'h8;

  localparam int CLR_EN_BIT  = 4;
  localparam int CLR_SEL_LSB = 5;
  localparam int CLR_SEL_W   = 3;
endpackage

// File: rtl/pwm_cap_sync.sv
module pwm_cap_sync #(
  parameter int N_CAP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CAP-1:0] cap_i,
  output logic [N_CAP-1:0] rise_o,
  output logic [N_CAP-1:0] fall_o
);
  for (genvar g = 0; g < N_CAP; g++) begin : g_ch
    // two sync stages plus one history stage
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], cap_i[g]};
    end
    assign rise_o[g] = sh_q[1] & ~sh_q[2];
    assign fall_o[g] = ~sh_q[1] & sh_q[2];
  end
endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] pre_lim_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PRE_W-1:0] pre_o,
  output logic             tick_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;

  // >= keeps a lowered limit from running the prescaler round its full range
  assign tick_o = (pre_q >= pre_lim_i);
  assign wrap_o = tick_o && (cnt_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
      if (tick_o) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;
endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             pwm_en_i,
  input  logic             level_i,
  output logic             out_o
);
  logic pwm_q;
  logic hit;

  assign hit = tick_i && !wrap_i && ((cnt_i + CNT_W'(1)) == match_i);

  // rollover and clear take priority over a coincident match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pwm_q <= 1'b0;
    else if (clear_i || wrap_i)  pwm_q <= 1'b0;
    else if (hit)                pwm_q <= 1'b1;
  end

  assign out_o = pwm_en_i ? pwm_q : level_i;
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int N_PWM = 3,
  parameter int N_CAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CAP-1:0]  cap_i,
  output logic [N_PWM-1:0]  pwm_o
);
  localparam int SEL_CH_W = CLR_SEL_W - 1;

  logic [PRE_W-1:0]            pre_lim_q;
  logic [CNT_W-1:0]            period_q;
  logic                        clr_en_q;
  logic [CLR_SEL_W-1:0]        clr_sel_q;
  logic [N_PWM-1:0]            mode_q;
  logic [N_PWM-1:0]            level_q;
  logic [N_PWM-1:0][CNT_W-1:0] match_q;

  logic [N_CAP-1:0] cap_rise, cap_fall;
  logic [SEL_CH_W-1:0] sel_ch;
  logic edge_hit, clear;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic tick, wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_lim_q <= '0;
      period_q  <= '0;
      clr_en_q  <= 1'b0;
      clr_sel_q <= '0;
      mode_q    <= '0;
      level_q   <= '0;
      match_q   <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_PRESCALE: pre_lim_q <= wdata_i[PRE_W-1:0];
        A_PERIOD:   period_q  <= wdata_i[CNT_W-1:0];
        A_CLRCFG: begin
          clr_en_q  <= wdata_i[CLR_EN_BIT];
          clr_sel_q <= wdata_i[CLR_SEL_LSB +: CLR_SEL_W];
        end
        A_MODE:     mode_q  <= wdata_i[N_PWM-1:0];
        A_LEVEL:    level_q <= wdata_i[N_PWM-1:0];
        default: ;
      endcase
      for (int i = 0; i < N_PWM; i++) begin
        if (addr_i == ADDR_W'(int'(A_MATCH_BASE) + i)) match_q[i] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PRESCALE: rdata_o[PRE_W-1:0] = pre_lim_q;
      A_COUNT:    rdata_o[CNT_W-1:0] = cnt;
      A_PERIOD:   rdata_o[CNT_W-1:0] = period_q;
      A_CLRCFG: begin
        rdata_o[CLR_EN_BIT]                 = clr_en_q;
        rdata_o[CLR_SEL_LSB +: CLR_SEL_W]   = clr_sel_q;
      end
      A_MODE:     rdata_o[N_PWM-1:0] = mode_q;
      A_LEVEL:    rdata_o[N_PWM-1:0] = level_q;
      default: ;
    endcase
    for (int i = 0; i < N_PWM; i++) begin
      if (addr_i == ADDR_W'(int'(A_MATCH_BASE) + i)) rdata_o[CNT_W-1:0] = match_q[i];
    end
  end

  pwm_cap_sync #(.N_CAP(N_CAP)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_i),
    .rise_o (cap_rise),
    .fall_o (cap_fall)
  );

  // select: low bit picks falling, upper bits pick the channel
  assign sel_ch   = clr_sel_q[CLR_SEL_W-1:1];
  assign edge_hit = clr_sel_q[0] ? cap_fall[sel_ch] : cap_rise[sel_ch];
  assign clear    = clr_en_q && edge_hit;

  pwm_tick_counter #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_lim_i (pre_lim_q),
    .period_i  (period_q),
    .clear_i   (clear),
    .cnt_o     (cnt),
    .pre_o     (pre),
    .tick_o    (tick),
    .wrap_o    (wrap)
  );

  for (genvar g = 0; g < N_PWM; g++) begin : g_out
    pwm_chan_out #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .wrap_i   (wrap),
      .clear_i  (clear),
      .cnt_i    (cnt),
      .match_i  (match_q[g]),
      .pwm_en_i (mode_q[g]),
      .level_i  (level_q[g]),
      .out_o    (pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm_match_timer_chk.sv
module pwm_match_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int N_PWM = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick_i,
  input logic                        wrap_i,
  input logic                        clear_i,
  input logic [CNT_W-1:0]            cnt_i,
  input logic [PRE_W-1:0]            pre_i,
  input logic [N_PWM-1:0]            mode_i,
  input logic [N_PWM-1:0][CNT_W-1:0] match_i,
  input logic [N_PWM-1:0]            pwm_o
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(cnt_i));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wrap_i && !clear_i) |=> (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !clear_i) |=> (cnt_i == '0));

  a_r8_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_i == '0 && pre_i == '0));

  for (genvar g = 0; g < N_PWM; g++) begin : g_chk
    a_r5_low_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((wrap_i || clear_i) && mode_i[g]) |=> (!mode_i[g] || !pwm_o[g]));

    a_r4_rise_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[g] && $past(mode_i[g]) && $rose(pwm_o[g])) |-> (cnt_i == $past(match_i[g])));
  end
endmodule

bind pwm_match_timer pwm_match_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .N_PWM(N_PWM)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick),
  .wrap_i  (wrap),
  .clear_i (clear),
  .cnt_i   (cnt),
  .pre_i   (pre),
  .mode_i  (mode_q),
  .match_i (match_q),
  .pwm_o   (pwm_o)
);

// File: tb/pwm_match_timer_test.sv
module pwm_match_timer_test;
  import pwm_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = A_COUNT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap = 4'b1000;
  logic [2:0]  pwm;

  always #4 clk = ~clk;

  pwm_match_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cap_i(cap), .pwm_o(pwm)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {int at; logic [2:0] exp;} sb_item_t;
  sb_item_t sb[$];
  sb_item_t it;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // prescale 2, period 5, match 2/5/0: 18-clock frame after a clear
  function automatic logic [2:0] exp_at(int k);
    int pos = k % 18;
    return {1'b0, logic'(pos >= 15), logic'(pos >= 6)};
  endfunction

  task automatic push_window(int base, int n);
    for (int k = 0; k < n; k++) sb.push_back('{base + 3 + k, exp_at(k)});
  endtask

  // monitor: R4 R5 R6 per scheduled slot
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      if (it.at == cyc) check("R4 R5 R6 pwm_o", {29'd0, pwm}, {29'd0, it.exp});
      else              check("R4 R5 R6 slot missed", 32'd0, 32'd1);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = A_COUNT;
  endtask

  task automatic rd_check(string tag, logic [3:0] a, logic [31:0] exp);
    addr = a;
    #1;
    check(tag, rdata, exp);
    addr = A_COUNT;
  endtask

  task automatic wait_k(int base, int k);
    while (cyc < base + 3 + k) @(negedge clk);
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check("R1 pwm_o in reset", {29'd0, pwm}, 32'd0);
    rd_check("R1 prescale", A_PRESCALE, 0);
    rd_check("R1 period", A_PERIOD, 0);
    rd_check("R1 clrcfg", A_CLRCFG, 0);
    rd_check("R1 mode", A_MODE, 0);
    rd_check("R1 match0", A_MATCH_BASE, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pwm_o after reset", {29'd0, pwm}, 32'd0);

    wr(A_PRESCALE, 2);
    wr(A_PERIOD, 5);
    wr(A_MATCH_BASE, 2);
    wr(A_MATCH_BASE + 4'd1, 5);
    wr(A_MATCH_BASE + 4'd2, 0);   // R6: match coincides with rollover
    wr(A_CLRCFG, 32'h10);         // R8: enable, channel 0 rising
    wr(A_MODE, 7);
    repeat (2) @(negedge clk);

    base = cyc;
    cap[0] = 1'b1;
    push_window(base, 90);
    wait_k(base, 0);  rd_check("R8 count cleared", A_COUNT, 0);
    wait_k(base, 7);  rd_check("R2 count paced", A_COUNT, 2);
    wait_k(base, 20); rd_check("R3 count rolled over", A_COUNT, 0);
    wait_k(base, 30); cap[1] = 1'b1; cap[0] = 1'b0;  // R9 unselected edges
    wait_k(base, 40); wr(A_CLRCFG, 32'hE0);          // R9 disabled, ch3 falling
    wait_k(base, 45); cap[3] = 1'b0;
    wait_k(base, 58); rd_check("R9 no clear", A_COUNT, 1);
    drain();

    cap[3] = 1'b1;
    repeat (5) @(negedge clk);
    wr(A_CLRCFG, 32'hF0);         // R8: enable, channel 3 falling
    repeat (3) @(negedge clk);
    base = cyc;
    cap[3] = 1'b0;
    push_window(base, 40);
    wait_k(base, 10); rd_check("R8 falling clear", A_COUNT, 3);
    drain();

    wr(A_MODE, 3);
    wr(A_LEVEL, 4);
    check("R7 level high", {31'd0, pwm[2]}, 32'd1);
    wr(A_LEVEL, 0);
    check("R7 level low", {31'd0, pwm[2]}, 32'd0);
    wr(A_MODE, 0);
    wr(A_LEVEL, 3);
    check("R7 all match mode", {29'd0, pwm}, 32'd3);

    wr(A_MODE, 32'hFFFF_FFF8);
    rd_check("R10 mode reserved", A_MODE, 0);
    wr(A_LEVEL, 32'hFFFF_FFFF);
    rd_check("R10 level reserved", A_LEVEL, 7);
    wr(A_CLRCFG, 32'hFFFF_FFFF);
    rd_check("R10 clrcfg reserved", A_CLRCFG, 32'hF0);
    wr(A_PRESCALE, 32'hFFFF_FFFF);
    rd_check("R10 prescale reserved", A_PRESCALE, 32'h0000_FFFF);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule